// File: doc/BRIEF.md
# Translation Buffer with Test Register Access

This block is a 32-entry translation buffer arranged as 8 sets of 4 ways, reached only through a pair of software-visible test registers: a command register and a data register. Software first loads the data register with a physical page number and a placement choice. It then writes the command register with a linear page, a valid bit, attribute tags and a command bit. Depending on that command bit, the block either installs an entry or searches the buffer for one.

Each stored entry keeps a dirty, a user and a writable attribute. A search request carries each attribute as a true/complement pair, so any attribute can be left as a don't-care. A search counts as a hit only when exactly one way of the indexed set matches. On a hit, the matching entry's contents are copied back into the register pair. A separate flush input, pulsed when the page-directory base is rewritten, invalidates every entry. All test-register writes are ignored while paging is enabled.

Top module: `tlbt_top`

## Requirements
- R1: After synchronous reset, both register readbacks are zero, the replacement pointer is 0, and no entry is valid, so any search misses.
- R2: A data-register write stores the physical page (bits 31:12), the hit/placement flag (bit 4) and the way field (bits 3:2). All other bits read back as 0.
- R3: A command-register write with bit 0 = 0 installs an entry. The set is linear bits 14:12, the tag is linear bits 31:15, the valid bit is bit 11, and the dirty, user and writable attributes are bits 10, 8 and 6. The physical page comes from the data register. When the data-register flag is 1, the way field selects the way.
- R4: When the data-register flag is 0, the way is chosen by a 2-bit pointer that starts at 0 and advances by one, wrapping around, after each such write.
- R5: A command-register write with bit 0 = 1 starts a search, and its result shows on the readbacks one clock after the write. On a hit, the data register holds the entry's physical page, flag 1 and the matching way. The command register then shows valid = 1 and each attribute pair loaded as true (bits 10, 8, 6) and complement (bits 9, 7, 5).
- R6: A search with no matching way, or with more than one, clears the flag to 0 and leaves every other register field unchanged.
- R7: For each attribute, the request pair (true, complement) works as follows: (1,0) needs the stored bit to be 1, (0,1) needs it to be 0, (0,0) is a don't-care, and (1,1) never matches.
- R8: A flush pulse invalidates all entries. If an install happens in the same cycle, the flush wins and the new entry is left invalid.
- R9: While paging_on is 1, writes to both registers are ignored. The readbacks are unchanged and no entry is installed.
- R10: Right after a command-register write, its readback shows the written bits 31:5 and bit 0, with bits 4:1 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_on | input | 1 | Paging enabled; blocks test-register writes |
| cmd_wr | input | 1 | Command-register write strobe |
| cmd_wdata | input | 32 | Command-register write value |
| dat_wr | input | 1 | Data-register write strobe |
| dat_wdata | input | 32 | Data-register write value |
| flush | input | 1 | Invalidate all entries |
| cmd_rdata | output | 32 | Command-register readback |
| dat_rdata | output | 32 | Data-register readback |

## Verification
The assertions assume that no register write arrives in the clock that follows a search command, when the search result is being loaded. They also assume that paging_on does not change while a search result is pending. The stimulus meets both assumptions by following every command write with an idle cycle and by changing paging_on only alongside a strobe. Random installs use a handful of tags across four sets, so hits, misses and multiple matches all occur. Directed cases cover pointer wrap-around, every attribute pair, and a flush that coincides with an install.

// File: rtl/tlbt_pkg.sv
package tlbt_pkg;
    localparam int VA_W   = 32;
    localparam int PG_LSB = 12;
    localparam int SET_W  = 3;
    localparam int WAY_W  = 2;
    localparam int PN_W   = VA_W - PG_LSB;
    localparam int TAG_W  = PN_W - SET_W;
    localparam int NSETS  = 1 << SET_W;
    localparam int NWAYS  = 1 << WAY_W;

    typedef struct packed {
        logic d;
        logic u;
        logic w;
    } attr_t;

    typedef struct packed {
        logic [PN_W-1:0] lpage;
        logic            vld;
        attr_t           a_t;
        attr_t           a_c;
        logic            lookup;
    } cmd_t;

    typedef struct packed {
        logic [PN_W-1:0]  ppn;
        logic             flag;
        logic [WAY_W-1:0] way;
    } dat_t;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PN_W-1:0]  ppn;
        attr_t            attr;
    } entry_t;

    function automatic cmd_t cmd_unpack(input logic [VA_W-1:0] v);
        cmd_t c;
        c.lpage  = v[VA_W-1:PG_LSB];
        c.vld    = v[PG_LSB-1];
        c.a_t    = '{d: v[PG_LSB-2], u: v[PG_LSB-4], w: v[PG_LSB-6]};
        c.a_c    = '{d: v[PG_LSB-3], u: v[PG_LSB-5], w: v[PG_LSB-7]};
        c.lookup = v[0];
        return c;
    endfunction

    function automatic logic [VA_W-1:0] cmd_pack(input cmd_t c);
        return {c.lpage, c.vld, c.a_t.d, c.a_c.d, c.a_t.u, c.a_c.u,
                c.a_t.w, c.a_c.w, {(PG_LSB-8){1'b0}}, c.lookup};
    endfunction

    function automatic dat_t dat_unpack(input logic [VA_W-1:0] v);
        dat_t d;
        d.ppn  = v[VA_W-1:PG_LSB];
        d.flag = v[WAY_W+2];
        d.way  = v[WAY_W+1:2];
        return d;
    endfunction

    function automatic logic [VA_W-1:0] dat_pack(input dat_t d);
        return {d.ppn, {(PG_LSB-3-WAY_W){1'b0}}, d.flag, d.way, 2'b00};
    endfunction

    // true/complement request test against one stored attribute set
    function automatic logic attr_ok(input attr_t st, input attr_t rt, input attr_t rc);
        return ((rt & ~st) == '0) && ((rc & st) == '0);
    endfunction
endpackage

// File: rtl/tlbt_repl.sv
module tlbt_repl #(
    parameter int PTR_W = tlbt_pkg::WAY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/tlbt_hitenc.sv
module tlbt_hitenc #(
    parameter int WAYS_W = tlbt_pkg::WAY_W,
    localparam int NW    = 1 << WAYS_W
) (
    input  logic [NW-1:0]     match,
    output logic              hit,
    output logic [WAYS_W-1:0] hway
);
    always_comb begin
        hway = '0;
        for (int i = 0; i < NW; i++)
            if (match[i]) hway = WAYS_W'(i);
        hit = ($countones(match) == 1);
    end
endmodule

// File: rtl/tlbt_array.sv
module tlbt_array
    import tlbt_pkg::*;
#(
    parameter int SETS_W = tlbt_pkg::SET_W,
    parameter int WAYS_W = tlbt_pkg::WAY_W,
    localparam int NS    = 1 << SETS_W,
    localparam int NW    = 1 << WAYS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              we,
    input  logic [SETS_W-1:0] wset,
    input  logic [WAYS_W-1:0] wway,
    input  entry_t            wentry,
    input  logic [SETS_W-1:0] rset,
    input  logic [TAG_W-1:0]  req_tag,
    input  attr_t             req_at,
    input  attr_t             req_ac,
    input  logic [WAYS_W-1:0] sel_way,
    output logic [NW-1:0]     match,
    output logic [PN_W-1:0]   sel_ppn,
    output attr_t             sel_attr
);
    entry_t mem [NS][NW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++)
                    mem[s][w] <= '0;
        end else begin
            if (we)
                mem[wset][wway] <= wentry;
            if (flush)
                for (int s = 0; s < NS; s++)
                    for (int w = 0; w < NW; w++)
                        mem[s][w].vld <= 1'b0;
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_way
        entry_t e;
        assign e        = mem[rset][w];
        assign match[w] = e.vld && (e.tag == req_tag) && attr_ok(e.attr, req_at, req_ac);
    end

    assign sel_ppn  = mem[rset][sel_way].ppn;
    assign sel_attr = mem[rset][sel_way].attr;
endmodule

// File: rtl/tlbt_top.sv
module tlbt_top
    import tlbt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            paging_on,
    input  logic            cmd_wr,
    input  logic [VA_W-1:0] cmd_wdata,
    input  logic            dat_wr,
    input  logic [VA_W-1:0] dat_wdata,
    input  logic            flush,
    output logic [VA_W-1:0] cmd_rdata,
    output logic [VA_W-1:0] dat_rdata
);
    cmd_t             cmd_q, cmd_in;
    dat_t             dat_q;
    logic             lk_pend;
    logic             cmd_we, dat_we, ent_we;
    logic [WAY_W-1:0] ptr, wway, hway;
    logic [NWAYS-1:0] match;
    logic             hit;
    logic [PN_W-1:0]  sel_ppn;
    attr_t            sel_attr;
    entry_t           wentry;

    assign cmd_in = cmd_unpack(cmd_wdata);
    assign cmd_we = cmd_wr && !paging_on && !lk_pend;
    assign dat_we = dat_wr && !paging_on && !lk_pend;
    assign ent_we = cmd_we && !cmd_in.lookup;
    assign wway   = dat_q.flag ? dat_q.way : ptr;

    always_comb begin
        wentry.vld  = cmd_in.vld;
        wentry.tag  = cmd_in.lpage[PN_W-1:SET_W];
        wentry.ppn  = dat_q.ppn;
        wentry.attr = cmd_in.a_t;
    end

    tlbt_repl #(.PTR_W(WAY_W)) u_repl (
        .clk (clk),
        .rst (rst),
        .adv (ent_we && !dat_q.flag),
        .ptr (ptr)
    );

    tlbt_array #(.SETS_W(SET_W), .WAYS_W(WAY_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .we       (ent_we),
        .wset     (cmd_in.lpage[SET_W-1:0]),
        .wway     (wway),
        .wentry   (wentry),
        .rset     (cmd_q.lpage[SET_W-1:0]),
        .req_tag  (cmd_q.lpage[PN_W-1:SET_W]),
        .req_at   (cmd_q.a_t),
        .req_ac   (cmd_q.a_c),
        .sel_way  (hway),
        .match    (match),
        .sel_ppn  (sel_ppn),
        .sel_attr (sel_attr)
    );

    tlbt_hitenc #(.WAYS_W(WAY_W)) u_hit (
        .match (match),
        .hit   (hit),
        .hway  (hway)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            dat_q   <= '0;
            lk_pend <= 1'b0;
        end else begin
            lk_pend <= cmd_we && cmd_in.lookup;
            if (lk_pend) begin
                dat_q.flag <= hit;
                if (hit) begin
                    dat_q.ppn <= sel_ppn;
                    dat_q.way <= hway;
                    cmd_q.vld <= 1'b1;
                    cmd_q.a_t <= sel_attr;
                    cmd_q.a_c <= ~sel_attr;
                end
            end else begin
                if (cmd_we) cmd_q <= cmd_in;
                if (dat_we) dat_q <= dat_unpack(dat_wdata);
            end
        end
    end

    assign cmd_rdata = cmd_pack(cmd_q);
    assign dat_rdata = dat_pack(dat_q);
endmodule

// File: rtl/tlbt_chk.sv
module tlbt_chk #(
    parameter int PTR_W = tlbt_pkg::WAY_W,
    localparam int NW   = 1 << PTR_W
) (
    input logic             clk,
    input logic             rst,
    input logic             paging_on,
    input logic             cmd_wr,
    input logic             cmd_op,
    input logic             flush,
    input logic [31:0]      cmd_rdata,
    input logic [31:0]      dat_rdata,
    input logic             lk_pend,
    input logic [NW-1:0]    match,
    input logic [PTR_W-1:0] ptr
);
    // R1
    reset_clears_regs_chk: assert property (@(posedge clk)
        rst |=> (cmd_rdata == '0 && dat_rdata == '0 && ptr == '0));

    // R4
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !paging_on && !lk_pend && !cmd_op && !dat_rdata[4])
        |=> ptr == PTR_W'($past(ptr) + 1'b1));

    // R5
    hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
        lk_pend |=> dat_rdata[4] == ($countones($past(match)) == 1));

    // R6
    miss_keeps_page_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_pend && $countones(match) != 1) |=> $stable(dat_rdata[31:12]));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> match == '0);

    // R9
    paging_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (paging_on && !lk_pend) |=> ($stable(cmd_rdata) && $stable(dat_rdata)));
endmodule

bind tlbt_top tlbt_chk #(.PTR_W(tlbt_pkg::WAY_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .paging_on (paging_on),
    .cmd_wr    (cmd_wr),
    .cmd_op    (cmd_wdata[0]),
    .flush     (flush),
    .cmd_rdata (cmd_rdata),
    .dat_rdata (dat_rdata),
    .lk_pend   (lk_pend),
    .match     (match),
    .ptr       (ptr)
);

// File: tb/tb_tlbt_top.sv
`timescale 1ns/1ps
module tb_tlbt_top;
    localparam logic [31:0] CMASK = 32'hFFFF_FFE1;
    localparam logic [31:0] DMASK = 32'hFFFF_F01C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        paging_on = 1'b0;
    logic        cmd_wr = 1'b0, dat_wr = 1'b0, flush = 1'b0;
    logic [31:0] cmd_wdata = '0, dat_wdata = '0;
    logic [31:0] cmd_rdata, dat_rdata;

    int nvec = 0, nfail = 0;
    bit done = 0;

    // reference model
    bit          m_vld  [8][4];
    logic [16:0] m_tag  [8][4];
    logic [19:0] m_ppn  [8][4];
    logic [2:0]  m_attr [8][4];
    logic [1:0]  m_ptr;
    logic [31:0] m_cmd, m_dat;

    always #2 clk = ~clk;

    tlbt_top dut (
        .clk(clk), .rst(rst), .paging_on(paging_on),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .flush(flush), .cmd_rdata(cmd_rdata), .dat_rdata(dat_rdata)
    );

    function automatic logic [31:0] mk_cmd(input logic [19:0] lp, input bit v,
        input bit d, input bit dn, input bit u, input bit un,
        input bit w, input bit wn, input bit op);
        return {lp, v, d, dn, u, un, w, wn, 4'b0, op};
    endfunction

    function automatic logic [31:0] mk_dat(input logic [19:0] pp, input bit fl, input logic [1:0] wy);
        return {pp, 7'b0, fl, wy, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, cmd_rdata, m_cmd);
        chk(req, dat_rdata, m_dat);
    endtask

    task automatic model_clear();
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    endtask

    task automatic model_install(input logic [31:0] v);
        int s;
        logic [1:0] wy;
        s  = int'(v[14:12]);
        wy = m_dat[4] ? m_dat[3:2] : m_ptr;
        if (!m_dat[4]) m_ptr = m_ptr + 2'd1;
        m_vld[s][wy]  = v[11];
        m_tag[s][wy]  = v[31:15];
        m_ppn[s][wy]  = m_dat[31:12];
        m_attr[s][wy] = {v[10], v[8], v[6]};
    endtask

    task automatic model_lookup();
        int s, cnt;
        logic [1:0] hw;
        logic [2:0] a;
        bit ok;
        s = int'(m_cmd[14:12]);
        cnt = 0;
        hw = 0;
        for (int w = 0; w < 4; w++) begin
            a  = m_attr[s][w];
            ok = m_vld[s][w] && (m_tag[s][w] == m_cmd[31:15])
                 && !(m_cmd[10] && !a[2]) && !(m_cmd[9] && a[2])
                 && !(m_cmd[8]  && !a[1]) && !(m_cmd[7] && a[1])
                 && !(m_cmd[6]  && !a[0]) && !(m_cmd[5] && a[0]);
            if (ok) begin cnt++; hw = 2'(w); end
        end
        if (cnt == 1) begin
            a = m_attr[s][hw];
            m_dat = mk_dat(m_ppn[s][hw], 1'b1, hw);
            m_cmd[11:5] = {1'b1, a[2], ~a[2], a[1], ~a[1], a[0], ~a[0]};
        end else begin
            m_dat[4] = 1'b0;
        end
    endtask

    task automatic do_dat(input logic [31:0] v, input bit pg, input string req);
        @(negedge clk);
        dat_wr = 1; dat_wdata = v; paging_on = pg;
        @(negedge clk);
        dat_wr = 0; paging_on = 0;
        if (!pg) m_dat = v & DMASK;
        chk_regs(req);
    endtask

    task automatic do_cmd(input logic [31:0] v, input bit pg, input bit fl, input string req);
        @(negedge clk);
        cmd_wr = 1; cmd_wdata = v; paging_on = pg; flush = fl;
        @(negedge clk);
        cmd_wr = 0; paging_on = 0; flush = 0;
        if (!pg) begin
            m_cmd = v & CMASK;
            if (!v[0]) model_install(v);
        end
        if (fl) model_clear();
        @(negedge clk);
        if (!pg && v[0]) model_lookup();
        chk_regs(req);
    endtask

    task automatic do_flush(input string req);
        @(negedge clk);
        flush = 1;
        @(negedge clk);
        flush = 0;
        model_clear();
        chk_regs(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        m_ptr = 0; m_cmd = 0; m_dat = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk_regs("R1 reset readback");
        do_cmd(mk_cmd(20'h12345, 0, 0,0,0,0,0,0, 1), 0, 0, "R1 empty lookup misses");

        // R2
        do_dat(32'hFFFF_FFFF, 0, "R2 data mask");
        // R3 / R10 / R5
        do_dat(mk_dat(20'hABCDE, 1, 2'd2), 0, "R2 data write");
        do_cmd(mk_cmd(20'h12345, 1, 1,0,0,1,1,0, 0), 0, 0, "R10 cmd readback after install");
        chk("R10 bits 4:1 zero", cmd_rdata & 32'h1E, 32'h0);
        do_cmd(mk_cmd(20'h12345, 0, 0,0,0,0,0,0, 1), 0, 0, "R5 hit at chosen way R3");
        chk("R5 hit flag", {31'b0, dat_rdata[4]}, 32'd1);

        // R4 pointer order 0,1,2,3,0
        do_dat(mk_dat(20'h11111, 0, 2'd3), 0, "R4 pointer mode");
        for (int i = 0; i < 5; i++)
            do_cmd(mk_cmd({17'(i + 8), 3'd1}, 1, 0,0,0,0,0,0, 0), 0, 0, "R4 pointer install");
        for (int i = 1; i < 5; i++) begin
            do_cmd(mk_cmd({17'(i + 8), 3'd1}, 0, 0,0,0,0,0,0, 1), 0, 0, "R4 pointer way");
            chk("R4 way order", {30'b0, dat_rdata[3:2]}, 32'(i % 4));
        end

        // R7 attribute pairs on entry D=1,U=0,W=1
        do_cmd(mk_cmd(20'h12345, 0, 1,0,0,0,0,0, 1), 0, 0, "R7 D(1,0) hit");
        do_cmd(mk_cmd(20'h12345, 0, 0,1,0,0,0,0, 1), 0, 0, "R7 D(0,1) miss");
        do_cmd(mk_cmd(20'h12345, 0, 1,1,0,0,0,0, 1), 0, 0, "R7 D(1,1) miss");
        do_cmd(mk_cmd(20'h12345, 0, 0,0,0,1,0,0, 1), 0, 0, "R7 U(0,1) hit");
        do_cmd(mk_cmd(20'h12345, 0, 0,0,0,0,0,1, 1), 0, 0, "R7 W(0,1) miss");

        // R6 multiple match
        do_dat(mk_dat(20'h55555, 1, 2'd3), 0, "R6 setup");
        do_cmd(mk_cmd(20'h12345, 1, 0,0,0,0,0,0, 0), 0, 0, "R6 duplicate install");
        do_cmd(mk_cmd(20'h12345, 0, 0,0,0,0,0,0, 1), 0, 0, "R6 multi-match miss keeps fields");

        // R9 paging blocks writes
        do_dat(32'h7777_7FFF, 1, "R9 data write ignored");
        do_cmd(mk_cmd(20'h0F0F2, 1, 0,0,0,0,0,0, 0), 1, 0, "R9 cmd write ignored");
        do_cmd(mk_cmd(20'h0F0F2, 0, 0,0,0,0,0,0, 1), 0, 0, "R9 no entry installed");

        // R8 flush
        do_flush("R8 flush keeps regs");
        do_cmd(mk_cmd(20'h12347, 0, 0,0,0,0,0,0, 1), 0, 0, "R8 flushed lookup misses");
        do_dat(mk_dat(20'h22222, 1, 2'd0), 0, "R8 setup");
        do_cmd(mk_cmd(20'h00010, 1, 0,0,0,0,0,0, 0), 0, 1, "R8 flush with install");
        do_cmd(mk_cmd(20'h00010, 0, 0,0,0,0,0,0, 1), 0, 0, "R8 flush wins");

        // random phase
        for (int it = 0; it < 600; it++) begin
            int k;
            logic [31:0] r;
            k = int'($urandom % 16);
            r = $urandom;
            if (k < 4)
                do_dat(r, (k == 0), "R2 R9 random data");
            else if (k < 9)
                do_cmd({17'($urandom % 3), 3'($urandom % 4), r[11:1], 1'b0}, (k == 4), 0,
                       "R3 R4 random install");
            else if (k < 15)
                do_cmd({17'($urandom % 3), 3'($urandom % 4), r[11:1], 1'b1}, 0, 0,
                       "R5 R6 R7 random lookup");
            else
                do_flush("R8 random flush");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule